// File: doc/BRIEF.md
# Host Write FIFO Wait-State Controller

This block sits between a host I/O port and a drawing engine. Host writes to engine registers are queued in a small FIFO. Each entry holds one data word and the register tag taken from the write address. The engine drains the queue at its own pace through a pop strobe. When the queue gets too busy, the block holds the host off by pulling ready low in the same cycle as the write strobe. The host keeps its write on the bus until ready returns.

The stall threshold is chosen by a policy input. With the policy input low, the host is held off only while the queue is full. With it high, the host is held off once the queue is at least half full. Writes to the compatibility register class (address MSB set) ignore the policy and are held off only when the queue is full, so no data is ever lost.

A width input selects 16-bit or 8-bit host writes. In 8-bit mode, address bit 0 selects the byte. The low byte is parked in a staging register, and the entry is pushed when the high byte arrives.

The packer is a two-state machine:
- `P_IDLE`, the reset state with nothing staged.
- `P_LOW_HELD`, a low byte waiting.

Its transitions:
- stage: `P_IDLE`→`P_LOW_HELD` on a low-byte write.
- pair: `P_LOW_HELD`→`P_IDLE` on a high-byte write, which pushes the entry.
- replace: `P_LOW_HELD`→`P_LOW_HELD` on another low-byte write.
- lone-high: `P_IDLE`→`P_IDLE` on a high-byte write, which pushes with a zero low byte.
- flush: any state→`P_IDLE` whenever 16-bit mode is selected.

The wait decode reports one of three causes: `W_OPEN`, `W_FULL` or `W_HALF`.

Top module: `hwq_ctrl`

## Requirements
- R1: After reset the queue is empty (`eng_valid` low), nothing is staged, and `host_rdy` is high.
- R2: With `pol_half` low, a write with the queue holding 16 entries sees `host_rdy` low in the same cycle and is not taken. With fewer entries the write is taken.
- R3: With `pol_half` high, a write to a normal register (address bit 6 = 0) sees `host_rdy` low whenever the queue holds 8 or more entries.
- R4: A write to the compatibility class (address bit 6 = 1) ignores `pol_half` and is held off only when the queue holds 16 entries.
- R5: In 16-bit mode (`mode_8bit` low), each taken write pushes one entry: the data is `wr_data` and the tag is address bits 5:1. Address bit 0 is ignored.
- R6: In 8-bit mode, a taken write with address bit 0 = 0 stages `wr_data[7:0]` and pushes nothing. A later write with bit 0 = 1 pushes `{wr_data[7:0], staged}` with that write's tag. A second low write replaces the staged byte. A high write with nothing staged pushes `{wr_data[7:0], 8'h00}`.
- R7: Whenever 16-bit mode is selected, any staged byte is discarded.
- R8: Entries leave in write order. `eng_rd` removes the head when `eng_valid` is high and has no effect on an empty queue. A push and a pop in the same cycle leave the occupancy unchanged.
- R9: The head entry's data and tag are readable on `eng_data` and `eng_tag` without being removed, and stay stable until popped.
- R10: When a pop brings the occupancy below the active threshold, `host_rdy` for a waiting write rises in the following cycle, and that write is then taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, held until `host_rdy` |
| wr_addr | input | 7 | Bit 6 compatibility class, bits 5:1 register tag, bit 0 byte select |
| wr_data | input | 16 | Host write data |
| pol_half | input | 1 | 1: stall at half full; 0: stall only when full |
| mode_8bit | input | 1 | 1: 8-bit host writes; 0: 16-bit |
| host_rdy | output | 1 | Low while a present write must wait |
| eng_rd | input | 1 | Engine pop strobe |
| eng_valid | output | 1 | Queue not empty |
| eng_data | output | 16 | Head entry data (test read) |
| eng_tag | output | 5 | Head entry tag (test read) |

## Verification
`host_rdy` is combinational from the current occupancy and the write on the bus. It is therefore sampled 1 ns after the inputs are driven at the falling edge, before the rising edge that would take the write. A taken write appears at the queue head one rising edge later, so head data, tag and `eng_valid` are sampled at the next falling edge. The occupancy is not on a port, so it is measured by draining the queue and counting pops. Readiness after a pop is sampled just after the edge that performed the pop.

// File: rtl/hwq_pkg.sv
package hwq_pkg;

    typedef enum logic [0:0] {
        P_IDLE     = 1'b0,
        P_LOW_HELD = 1'b1
    } pack_st_t;

    typedef enum logic [1:0] {
        W_OPEN = 2'd0,
        W_FULL = 2'd1,
        W_HALF = 2'd2
    } wait_cause_t;

endpackage

// File: rtl/hwq_fifo.sv
module hwq_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 5,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              pop_req,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic              valid,
    output logic [CNT_W-1:0]  count
);

    localparam int ENT_W = DATA_W + TAG_W;
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             pop;

    assign valid = (count != '0);
    assign pop   = pop_req && valid;
    assign {head_data, head_tag} = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= {push_data, push_tag};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8: the packer never pushes into a full queue
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != FULL_LVL));

    // R8: occupancy moves by at most one entry per cycle and stays bounded
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((count == $past(count)) || (count == $past(count) + 1'b1)
                  || (count + 1'b1 == $past(count))) && (count <= FULL_LVL));

endmodule

// File: rtl/hwq_pack.sv
module hwq_pack
    import hwq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 5,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              mode8,
    input  logic              byte_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic [TAG_W-1:0]  push_tag
);

    pack_st_t          st;
    pack_st_t          st_nxt;
    logic [HALF_W-1:0] stage;
    logic              stage_ld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= P_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (stage_ld) begin
            stage <= wr_data[HALF_W-1:0];
        end
    end

    always_comb begin
        st_nxt    = st;
        push      = 1'b0;
        push_data = wr_data;
        push_tag  = wr_tag;
        stage_ld  = 1'b0;
        if (!mode8) begin
            st_nxt = P_IDLE;
            push   = acc;
        end else begin
            unique case (st)
                P_IDLE: begin
                    if (acc && byte_hi) begin
                        push      = 1'b1;
                        push_data = {wr_data[HALF_W-1:0], {HALF_W{1'b0}}};
                    end else if (acc) begin
                        stage_ld = 1'b1;
                        st_nxt   = P_LOW_HELD;
                    end
                end
                P_LOW_HELD: begin
                    if (acc && byte_hi) begin
                        push      = 1'b1;
                        push_data = {wr_data[HALF_W-1:0], stage};
                        st_nxt    = P_IDLE;
                    end else if (acc) begin
                        stage_ld = 1'b1;
                    end
                end
                default: st_nxt = P_IDLE;
            endcase
        end
    end

    // R6: in byte mode only a high-byte write completes an entry
    a_r6_push_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (push && mode8) |-> byte_hi);

    // R7: a 16-bit mode cycle leaves nothing staged
    a_r7_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mode8 |=> (st == P_IDLE));

endmodule

// File: rtl/hwq_wait.sv
module hwq_wait
    import hwq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic             wr_en,
    input  logic             exempt,
    input  logic             pol_half,
    output logic             host_rdy
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);

    wait_cause_t cause;

    always_comb begin
        cause = W_OPEN;
        if (count == FULL_LVL) begin
            cause = W_FULL;
        end else if (pol_half && !exempt && (count >= HALF_LVL)) begin
            cause = W_HALF;
        end
    end

    always_comb begin
        unique case (cause)
            W_OPEN:  host_rdy = 1'b1;
            W_FULL:  host_rdy = !wr_en;
            W_HALF:  host_rdy = !wr_en;
            default: host_rdy = !wr_en;
        endcase
    end

endmodule

// File: rtl/hwq_ctrl.sv
module hwq_ctrl #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 5,
    localparam int ADDR_W = TAG_W + 2,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pol_half,
    input  logic              mode_8bit,
    output logic              host_rdy,
    input  logic              eng_rd,
    output logic              eng_valid,
    output logic [DATA_W-1:0] eng_data,
    output logic [TAG_W-1:0]  eng_tag
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);

    logic              exempt;
    logic              byte_hi;
    logic [TAG_W-1:0]  tag;
    logic              acc;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic [TAG_W-1:0]  push_tag;
    logic [CNT_W-1:0]  count;

    assign exempt  = wr_addr[ADDR_W-1];
    assign tag     = wr_addr[TAG_W:1];
    assign byte_hi = wr_addr[0];
    assign acc     = wr_en && host_rdy;

    hwq_wait #(.DEPTH(DEPTH)) u_wait (
        .count    (count),
        .wr_en    (wr_en),
        .exempt   (exempt),
        .pol_half (pol_half),
        .host_rdy (host_rdy)
    );

    hwq_pack #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .mode8     (mode_8bit),
        .byte_hi   (byte_hi),
        .wr_data   (wr_data),
        .wr_tag    (tag),
        .push      (push),
        .push_data (push_data),
        .push_tag  (push_tag)
    );

    hwq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .push_tag  (push_tag),
        .pop_req   (eng_rd),
        .head_data (eng_data),
        .head_tag  (eng_tag),
        .valid     (eng_valid),
        .count     (count)
    );

    // R2: a full queue always holds off a present write
    a_r2_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (count == FULL_LVL)) |-> !host_rdy);

    // R3: half-full policy holds off normal-class writes
    a_r3_half_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pol_half && !exempt && (count >= HALF_LVL)) |-> !host_rdy);

    // R4: compatibility-class writes proceed below full regardless of policy
    a_r4_exempt_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && exempt && (count != FULL_LVL)) |-> host_rdy);

    // R9: the head is stable while not popped and nothing was empty
    a_r9_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_rd) |=> ($stable(eng_data) && $stable(eng_tag)));

endmodule

// File: tb/test_hwq_ctrl.sv
module test_hwq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pol_half = 1'b0;
    logic        mode_8bit = 1'b0;
    logic        host_rdy;
    logic        eng_rd = 1'b0;
    logic        eng_valid;
    logic [15:0] eng_data;
    logic [4:0]  eng_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hwq_ctrl i_hwq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pol_half  (pol_half),
        .mode_8bit (mode_8bit),
        .host_rdy  (host_rdy),
        .eng_rd    (eng_rd),
        .eng_valid (eng_valid),
        .eng_data  (eng_data),
        .eng_tag   (eng_tag)
    );

    // {fill[4:0], pol_half, class, expected ready}
    localparam logic [7:0] VEC [11] = '{
        {5'd0,  1'b0, 1'b0, 1'b1},
        {5'd15, 1'b0, 1'b0, 1'b1},
        {5'd16, 1'b0, 1'b0, 1'b0},
        {5'd16, 1'b0, 1'b1, 1'b0},
        {5'd7,  1'b1, 1'b0, 1'b1},
        {5'd8,  1'b1, 1'b0, 1'b0},
        {5'd12, 1'b1, 1'b0, 1'b0},
        {5'd8,  1'b1, 1'b1, 1'b1},
        {5'd15, 1'b1, 1'b1, 1'b1},
        {5'd16, 1'b1, 1'b1, 1'b0},
        {5'd8,  1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; eng_rd = 1'b0;
        pol_half = 1'b0; mode_8bit = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1;
        while (!host_rdy) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic pop(output logic v, output logic [15:0] d, output logic [4:0] t);
        @(negedge clk);
        #1;
        v = eng_valid; d = eng_data; t = eng_tag;
        eng_rd = 1'b1;
        @(posedge clk);
        #1 eng_rd = 1'b0;
    endtask

    task automatic fill(input int n);
        for (int k = 0; k < n; k++) begin
            wr({1'b0, 5'(k), 1'b0}, 16'(k));
        end
    endtask

    task automatic drain(output int n, output logic [15:0] last);
        logic v; logic [15:0] d; logic [4:0] t;
        n = 0; last = '0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            #1;
            if (eng_valid) begin
                pop(v, d, t);
                n++; last = d;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic v; logic [15:0] d; logic [4:0] t;
        int n; logic [15:0] last;

        // R1: reset state
        do_reset();
        @(negedge clk); #1;
        chk("R1 valid after reset", eng_valid, 1'b0);
        chk("R1 ready after reset", host_rdy, 1'b1);

        // R2 R3 R4: threshold table
        for (int i = 0; i < 11; i++) begin
            do_reset();
            fill(int'(VEC[i][7:3]));
            @(negedge clk);
            pol_half = VEC[i][2];
            wr_en = 1'b1;
            wr_addr = {VEC[i][1], 5'd9, 1'b0};
            wr_data = 16'hCAFE;
            #1;
            chk($sformatf("R2/R3/R4 row %0d ready", i), host_rdy, VEC[i][0]);
            #1 wr_en = 1'b0;
        end

        // R1: reset empties a full queue
        do_reset();
        fill(16);
        do_reset();
        @(negedge clk); #1;
        chk("R1 valid after reset of full queue", eng_valid, 1'b0);

        // R5 R9 R8: 16-bit pushes, head read, ordering
        do_reset();
        wr({1'b0, 5'd3, 1'b0}, 16'hA5C3);
        wr({1'b0, 5'd7, 1'b1}, 16'h1234);
        @(negedge clk); #1;
        chk("R9 head data", eng_data, 16'hA5C3);
        chk("R5 head tag", eng_tag, 5'd3);
        @(negedge clk); #1;
        chk("R9 head stable", eng_data, 16'hA5C3);
        pop(v, d, t);
        chk("R8 first out", d, 16'hA5C3);
        pop(v, d, t);
        chk("R5 second data", d, 16'h1234);
        chk("R5 tag ignores bit0", t, 5'd7);
        @(negedge clk); #1;
        chk("R8 empty after drain", eng_valid, 1'b0);
        pop(v, d, t);
        wr({1'b0, 5'd1, 1'b0}, 16'h0F0F);
        @(negedge clk); #1;
        chk("R8 empty pop no effect", eng_data, 16'h0F0F);
        drain(n, last);
        chk("R8 empty pop count", n, 1);

        // R6: byte packing
        do_reset();
        mode_8bit = 1'b1;
        wr({1'b0, 5'd4, 1'b0}, 16'h99AB);
        @(negedge clk); #1;
        chk("R6 low byte no push", eng_valid, 1'b0);
        wr({1'b0, 5'd4, 1'b1}, 16'hFFCD);
        @(negedge clk); #1;
        chk("R6 paired data", eng_data, 16'hCDAB);
        chk("R6 paired tag", eng_tag, 5'd4);
        pop(v, d, t);
        wr({1'b0, 5'd2, 1'b0}, 16'h0011);
        wr({1'b0, 5'd2, 1'b0}, 16'h0022);
        wr({1'b0, 5'd6, 1'b1}, 16'h0033);
        pop(v, d, t);
        chk("R6 replaced low", d, 16'h3322);
        chk("R6 tag from high write", t, 5'd6);
        wr({1'b0, 5'd5, 1'b1}, 16'h0044);
        pop(v, d, t);
        chk("R6 lone high", d, 16'h4400);

        // R7: switching to 16-bit discards staged byte
        wr({1'b0, 5'd5, 1'b0}, 16'h0055);
        @(negedge clk); mode_8bit = 1'b0;
        @(negedge clk); mode_8bit = 1'b1;
        wr({1'b0, 5'd5, 1'b1}, 16'h0066);
        pop(v, d, t);
        chk("R7 staged discarded", d, 16'h6600);

        // R10: ready returns after a pop drops below threshold
        do_reset();
        fill(8);
        @(negedge clk);
        pol_half = 1'b1;
        wr_en = 1'b1; wr_addr = {1'b0, 5'd12, 1'b0}; wr_data = 16'hBEAD;
        #1;
        chk("R3 stall at half", host_rdy, 1'b0);
        eng_rd = 1'b1;
        @(posedge clk);
        #1 eng_rd = 1'b0;
        chk("R10 ready after pop", host_rdy, 1'b1);
        @(posedge clk);
        #1 wr_en = 1'b0;
        pol_half = 1'b0;
        drain(n, last);
        chk("R10 count after retry", n, 8);
        chk("R10 retried write last", last, 16'hBEAD);

        // R8: push and pop in the same cycle
        do_reset();
        fill(3);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {1'b0, 5'd8, 1'b0}; wr_data = 16'hBEEF;
        eng_rd = 1'b1;
        @(posedge clk);
        #1 begin wr_en = 1'b0; eng_rd = 1'b0; end
        drain(n, last);
        chk("R8 simultaneous count", n, 3);
        chk("R8 simultaneous last", last, 16'hBEEF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule